// File: doc/BRIEF.md
# Min-Sum Soft-Cancellation Processing Array

This block is the arithmetic core of an iterative soft-output polar decoder. It holds `LANES` identical processing lanes. Each lane takes three signed log-likelihood ratios `a`, `b` and `c` and one shared operation select. With the select low, a lane adds `b` and `c` with saturation and then combines `a` with that sum. With the select high, a lane combines `a` with `c` and then adds `b` with saturation. The combine step is the min-sum box-plus. Its result magnitude is the smaller of the two input magnitudes. Its sign is the exclusive-or of the two input sign bits.

Every arithmetic result is clipped to the symmetric range ±(2^(W−1)−1). The most negative two's-complement code is therefore never produced. If it arrives as an input, its magnitude is read as the largest legal magnitude. A frozen leaf is fed in as the value +(2^(W−1)−1), and an information leaf as 0.

The memory that surrounds the array can ask for the result it is writing in the current cycle to be reused at once. For this there is one forward flag per operand. A set flag replaces that operand, in every lane, with the result the array is presenting now. The operand path is combinational, and the lane results are captured in a single register stage.

Top module: `scan_pe_array`

## Requirements
- R1: While `rst_n` is low and after its release, until the first accepted operation, `res` is all zeros and `res_valid` is 0.
- R2: With `op_sel`=0, lane k outputs f(a, sat(b+c)). Here f(x,y) has magnitude min(|x|,|y|) and is negative exactly when the sign bits of x and y differ and that magnitude is non-zero.
- R3: With `op_sel`=1, lane k outputs sat(f(a,c)+b).
- R4: Every addition saturates to +SAT or −SAT, with SAT = 2^(W−1)−1. The code −2^(W−1) never appears on `res`.
- R5: An input equal to −2^(W−1) is taken as magnitude SAT when the minimum is formed.
- R6: A zero magnitude after the minimum gives a result of 0 before any later addition, whatever the sign bits are.
- R7: Lane k reads only bits [k*W +: W] of each operand bus and writes only bits [k*W +: W] of `res`. Lanes do not interact.
- R8: When `fwd_a`, `fwd_b` or `fwd_c` is 1, that operand in every lane is replaced by the value `res` holds during that same cycle. The memory-side input is ignored.
- R9: An operation driven with `in_valid`=1 appears on `res`, with `res_valid`=1, after the next rising clock edge. A cycle with `in_valid`=0 leaves `res` unchanged and drives `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands this cycle are to be processed |
| op_sel | input | 1 | 0: f(a,b+c); 1: f(a,c)+b |
| opa_mem | input | LANES*W | Operand a of every lane, lane k at [k*W +: W] |
| opb_mem | input | LANES*W | Operand b of every lane |
| opc_mem | input | LANES*W | Operand c of every lane |
| fwd_a | input | 1 | Take operand a from the current result |
| fwd_b | input | 1 | Take operand b from the current result |
| fwd_c | input | 1 | Take operand c from the current result |
| res | output | LANES*W | Registered lane results |
| res_valid | output | 1 | `res` was updated by the last edge |

## Verification
A narrow configuration of three lanes and W=4 is driven with every combination of the three 4-bit operands under both select values. Each lane receives a different rotation of the sweep index, so a crossed lane or a swapped operand is exposed. A directed set targets overflow of b+c and of f+b in both directions, and the most negative input code used as a magnitude. It also covers zero operands of either sign, which separate the sign logic from the magnitude logic. A chain of dependent operations with each forward flag set alone shows that the fed-back value is the current result and not the stale memory input. Idle cycles show that the output is held.

// File: rtl/scan_pe_pkg.sv
package scan_pe_pkg;
  typedef enum logic {
    OP_BOXSUM = 1'b0,  // f(a, b+c)
    OP_BOXADD = 1'b1   // f(a, c) + b
  } pe_op_e;
endpackage

// File: rtl/scan_pe_lane.sv
module scan_pe_lane
  import scan_pe_pkg::*;
#(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  input  pe_op_e              op,
  output logic signed [W-1:0] y
);
  localparam int SAT = (1 << (W-1)) - 1;
  localparam logic signed [W:0]   POS_X   = (W+1)'(SAT);
  localparam logic signed [W:0]   NEG_X   = -POS_X;
  localparam logic signed [W-1:0] MINCODE = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat_add(logic signed [W-1:0] x,
                                                   logic signed [W-1:0] z);
    logic signed [W:0] s;
    s = {x[W-1], x} + {z[W-1], z};
    if (s > POS_X)      return POS_X[W-1:0];
    else if (s < NEG_X) return NEG_X[W-1:0];
    else                return s[W-1:0];
  endfunction

  function automatic logic [W-2:0] magnitude(logic signed [W-1:0] x);
    logic signed [W-1:0] n;
    n = -x;
    if (x == MINCODE) return POS_X[W-2:0];
    else if (x[W-1])  return n[W-2:0];
    else              return x[W-2:0];
  endfunction

  function automatic logic signed [W-1:0] boxmin(logic signed [W-1:0] x,
                                                  logic signed [W-1:0] z);
    logic [W-2:0] mx, mz, m;
    logic signed [W-1:0] p;
    mx = magnitude(x);
    mz = magnitude(z);
    m  = (mx < mz) ? mx : mz;
    p  = {1'b0, m};
    return (x[W-1] ^ z[W-1]) ? -p : p;
  endfunction

  // named intermediate events
  logic signed [W-1:0] bc_sum;
  logic signed [W-1:0] mix_bc;
  logic signed [W-1:0] mix_c;
  logic signed [W-1:0] mix_c_plus_b;

  always_comb begin
    bc_sum       = sat_add(b, c);
    mix_bc       = boxmin(a, bc_sum);
    mix_c        = boxmin(a, c);
    mix_c_plus_b = sat_add(mix_c, b);
    y            = (op == OP_BOXADD) ? mix_c_plus_b : mix_bc;
  end

  // R4 the inner sum never reaches the asymmetric code
  always_comb begin
    r4_sum_range_chk: assert (bc_sum !== MINCODE || $isunknown(b) || $isunknown(c));
  end
endmodule

// File: rtl/scan_pe_fwd.sv
module scan_pe_fwd #(
  parameter int LANES = 8,
  parameter int W     = 6
) (
  input  logic [LANES*W-1:0] mem_in,
  input  logic [LANES*W-1:0] fb_in,
  input  logic               take_fb,
  output logic [LANES*W-1:0] opnd
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane_mux
    assign opnd[k*W +: W] = take_fb ? fb_in[k*W +: W] : mem_in[k*W +: W];
  end
endmodule

// File: rtl/scan_pe_array.sv
module scan_pe_array
  import scan_pe_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               op_sel,
  input  logic [LANES*W-1:0] opa_mem,
  input  logic [LANES*W-1:0] opb_mem,
  input  logic [LANES*W-1:0] opc_mem,
  input  logic               fwd_a,
  input  logic               fwd_b,
  input  logic               fwd_c,
  output logic [LANES*W-1:0] res,
  output logic               res_valid
);
  localparam int VW = LANES * W;
  localparam logic [W-1:0] MINCODE = {1'b1, {(W-1){1'b0}}};

  logic [VW-1:0] a_eff, b_eff, c_eff;
  logic [VW-1:0] lane_y;
  logic [VW-1:0] res_q;
  logic          vld_q;
  pe_op_e        op_e;

  assign op_e = pe_op_e'(op_sel);

  scan_pe_fwd #(.LANES(LANES), .W(W)) u_fwd_a (
    .mem_in(opa_mem), .fb_in(res_q), .take_fb(fwd_a), .opnd(a_eff));
  scan_pe_fwd #(.LANES(LANES), .W(W)) u_fwd_b (
    .mem_in(opb_mem), .fb_in(res_q), .take_fb(fwd_b), .opnd(b_eff));
  scan_pe_fwd #(.LANES(LANES), .W(W)) u_fwd_c (
    .mem_in(opc_mem), .fb_in(res_q), .take_fb(fwd_c), .opnd(c_eff));

  for (genvar k = 0; k < LANES; k++) begin : g_pe
    logic signed [W-1:0] la, lb, lc, ly;
    assign la = a_eff[k*W +: W];
    assign lb = b_eff[k*W +: W];
    assign lc = c_eff[k*W +: W];

    scan_pe_lane #(.W(W)) u_lane (
      .a(la), .b(lb), .c(lc), .op(op_e), .y(ly));

    assign lane_y[k*W +: W] = ly;

    // R4
    r4_no_mincode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_q[k*W +: W] != MINCODE);

    // R6
    r6_zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e == OP_BOXSUM && la == '0) |=> (res_q[k*W +: W] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= lane_y;
    end
  end

  assign res       = res_q;
  assign res_valid = vld_q;

  // R9
  r9_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R9
  r9_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res) && !res_valid));

  // R8
  r8_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a |-> (a_eff == res));
endmodule

// File: tb/scan_pe_array_test.sv
`timescale 1ns/1ps
module scan_pe_array_test;
  localparam int L   = 3;
  localparam int W   = 4;
  localparam int SAT = (1 << (W-1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, op_sel = 1'b0;
  logic fwd_a = 1'b0, fwd_b = 1'b0, fwd_c = 1'b0;
  logic [L*W-1:0] opa = '0, opb = '0, opc = '0;
  logic [L*W-1:0] res;
  logic res_valid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  int prev_exp [L];

  always #2 clk = ~clk;

  scan_pe_array #(.LANES(L), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa_mem(opa), .opb_mem(opb), .opc_mem(opc),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_c(fwd_c),
    .res(res), .res_valid(res_valid));

  function automatic int clip(int v);
    if (v > SAT) return SAT;
    if (v < -SAT) return -SAT;
    return v;
  endfunction

  function automatic int mag(int v);
    int m = (v < 0) ? -v : v;
    return (m > SAT) ? SAT : m;
  endfunction

  function automatic int mix(int x, int z);
    int m = (mag(x) < mag(z)) ? mag(x) : mag(z);
    return ((x < 0) != (z < 0)) ? -m : m;
  endfunction

  function automatic int model(int op, int a, int b, int c);
    if (op == 0) return mix(a, clip(b + c));
    return clip(mix(a, c) + b);
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'(signed'(v));
  endfunction

  function automatic int lane_res(int k);
    return sx(res[k*W +: W]);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // one operation: drive on a falling edge, check on the next falling edge
  task automatic run_op(string tag, int op, int av[L], int bv[L], int cv[L],
                        bit fa, bit fb, bit fc);
    int exp [L];
    in_valid = 1'b1; op_sel = op[0];
    fwd_a = fa; fwd_b = fb; fwd_c = fc;
    for (int k = 0; k < L; k++) begin
      int ea, eb, ec;
      opa[k*W +: W] = W'(av[k]);
      opb[k*W +: W] = W'(bv[k]);
      opc[k*W +: W] = W'(cv[k]);
      ea = fa ? prev_exp[k] : av[k];
      eb = fb ? prev_exp[k] : bv[k];
      ec = fc ? prev_exp[k] : cv[k];
      exp[k] = model(op, ea, eb, ec);
    end
    @(negedge clk);
    chk({tag, " valid (R9)"}, int'(res_valid), 1);
    for (int k = 0; k < L; k++) begin
      chk(tag, lane_res(k), exp[k]);
      if (res[k*W +: W] == {1'b1, {(W-1){1'b0}}}) chk("R4 min code", lane_res(k), -SAT);
      prev_exp[k] = exp[k];
    end
  endtask

  task automatic directed(string tag, int op, int a, int b, int c, int exp);
    int av[L], bv[L], cv[L];
    for (int k = 0; k < L; k++) begin av[k] = a; bv[k] = b; cv[k] = c; end
    run_op(tag, op, av, bv, cv, 0, 0, 0);
    chk({tag, " constant"}, lane_res(0), exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < L; k++) prev_exp[k] = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 res in reset", int'(res), 0);
    chk("R1 valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res after release", int'(res), 0);
    chk("R1 valid after release", int'(res_valid), 0);

    // R4 saturation, R5 most negative input, R6 zero magnitude
    directed("R4 b+c high", 0, 7, 6, 5, 7);
    directed("R4 b+c low", 0, 7, -8, -8, -7);
    directed("R4 f+b high", 1, 6, 7, 5, 7);
    directed("R4 f+b low", 1, -6, -8, 5, -7);
    directed("R5 a min code", 1, -8, 0, 5, -5);
    directed("R5 both min code", 1, -8, 0, -8, 7);
    directed("R6 a zero", 0, 0, -3, -2, 0);
    directed("R6 c zero neg a", 1, -5, 2, 0, 2);

    // R2 R3 R7 exhaustive sweep, each lane on its own rotation
    for (int t = 0; t < 4096; t++) begin
      for (int op = 0; op < 2; op++) begin
        int av[L], bv[L], cv[L];
        for (int k = 0; k < L; k++) begin
          int u = (t + k * 1365) % 4096;
          av[k] = sx(W'(u >> 8));
          bv[k] = sx(W'(u >> 4));
          cv[k] = sx(W'(u));
        end
        run_op(op == 0 ? "R2 R7 sweep" : "R3 R7 sweep", op, av, bv, cv, 0, 0, 0);
      end
    end

    // R8 forwarding, each flag alone, memory value is junk
    begin
      int av[L], bv[L], cv[L];
      for (int k = 0; k < L; k++) begin av[k] = 3 - k; bv[k] = k - 2; cv[k] = 5; end
      run_op("R8 seed", 1, av, bv, cv, 0, 0, 0);
      for (int k = 0; k < L; k++) av[k] = -8;
      run_op("R8 fwd a", 0, av, bv, cv, 1, 0, 0);
      for (int k = 0; k < L; k++) bv[k] = 7;
      run_op("R8 fwd b", 1, av, bv, cv, 0, 1, 0);
      for (int k = 0; k < L; k++) cv[k] = -7;
      run_op("R8 fwd c", 0, av, bv, cv, 0, 0, 1);
      run_op("R8 fwd all", 1, av, bv, cv, 1, 1, 1);
    end

    // R9 idle cycles hold the result
    begin
      logic [L*W-1:0] held;
      held = res;
      in_valid = 1'b0; fwd_a = 0; fwd_b = 0; fwd_c = 0;
      opa = '1; opb = '0; opc = '1; op_sel = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R9 hold res", int'(res == held), 1);
        chk("R9 idle valid", int'(res_valid), 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule